// File: doc/BRIEF.md
# Cache Tag and Control Store with Snoop Port

This block keeps the tag and line-state flags for a direct-mapped, physically addressed, write-back cache whose lines are 32 bytes long. Each line stores a tag, three state flags (valid, shared, dirty), one even-parity bit that covers the three flags, and a second even-parity bit that covers the tag. The data array is not part of this block. The number of lines is a parameter.

Two request streams come into the block. The processor side sends reads, writes and fills. The bus side sends snoop reads and snoop invalidates. When both are valid in the same cycle, the snoop wins. Every accepted request gets exactly one response, one cycle later. The response gives hit or miss, the line's flags as they were before the access, any parity error, and, on a processor miss, whether a dirty victim must be written back along with its tag and index.

Back-pressure rules: `snp_ready` is always high. `cpu_ready` is low in any cycle where `snp_valid` is high. A processor request must then hold `cpu_valid` and its payload until it sees `cpu_ready` high at a clock edge. The response side has no ready signal. `rsp_valid` is a one-cycle pulse, and the consumer must take the response in that cycle.

Top module: `cache_tag_store`

## Requirements
- R1: An address is split into a 5-bit byte offset in bits [4:0], a line index in the next IDX_W bits, and a tag in all bits above the index. Two addresses that differ only in their offset select the same line and compare equal.
- R2: After reset every line is invalid and `rsp_valid` is low. The first lookup to any line returns a miss, with no parity error and no write-back request.
- R3: A processor fill (`cpu_op` = 2) writes the request's tag into the line, sets valid, clears dirty, and takes shared from `cpu_fill_shared`. A later lookup with that tag hits and reports those flags.
- R4: A lookup whose tag differs from the tag stored in a valid line returns a miss.
- R5: A processor write (`cpu_op` = 1) that hits sets the line's dirty flag. A later processor read or write (`cpu_op` = 0 or 1) that misses on that line asserts `rsp_wb_req`, with `rsp_wb_tag` and `rsp_wb_idx` naming the stored victim.
- R6: A processor miss on a line that is invalid, or valid but clean, does not assert `rsp_wb_req`.
- R7: A snoop read (`snp_op` = 0) that hits sets the line's shared flag. The response reports the line's dirty flag in `rsp_dirty`, so the owner can supply the data.
- R8: A snoop invalidate (`snp_op` = 1) that hits clears valid. Later processor lookups to that line miss without a write-back request.
- R9: Parity is even for both fields. A lookup on a line whose flag parity or tag parity does not match raises `rsp_par_err`. It is then treated as a miss, with no write-back request and no state change. `cpu_fill_bad_par` bit 0 inverts the stored flag parity on a fill, and bit 1 inverts the stored tag parity.
- R10: When both request streams are valid, the snoop is accepted first and `cpu_ready` is low. The held processor request is accepted in the first cycle with no snoop.
- R11: Every accepted request produces `rsp_valid` exactly one cycle later, with `rsp_snoop` naming its source. A cycle with no accepted request produces no response.
- R12: A fill always rewrites a line with freshly computed parity, so a line that had reported a parity error hits cleanly after it is filled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Processor request accepted this cycle |
| cpu_op | input | 2 | 0 read, 1 write, 2 fill, 3 treated as read |
| cpu_addr | input | ADDR_W | Processor physical address |
| cpu_fill_shared | input | 1 | Value of the shared flag written by a fill |
| cpu_fill_bad_par | input | 2 | Fill parity inversion: bit 0 for flags, bit 1 for tag |
| snp_valid | input | 1 | Snoop request valid |
| snp_ready | output | 1 | Snoop accepted (always high) |
| snp_op | input | 1 | 0 snoop read, 1 snoop invalidate |
| snp_addr | input | ADDR_W | Snoop physical address |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_snoop | output | 1 | Response belongs to a snoop |
| rsp_hit | output | 1 | Lookup hit |
| rsp_shared | output | 1 | Shared flag of the hit line before the access |
| rsp_dirty | output | 1 | Dirty flag of the hit line before the access |
| rsp_par_err | output | 1 | Flag or tag parity mismatch |
| rsp_wb_req | output | 1 | Dirty victim must be written back |
| rsp_wb_tag | output | TAG_W | Tag of the victim |
| rsp_wb_idx | output | IDX_W | Index of the victim |

## Verification
The embedded assertions check, on every cycle, the rules that do not depend on stored contents. A response follows each acceptance, an idle cycle stays quiet, a snoop beats a processor request in the same cycle, a parity error never shows as a hit or a write-back, and a write-back request only ever comes from a processor miss. What the array holds can only be shown through sequences of requests, and the bench's directed scenarios cover this: fills followed by hits, dirty marking followed by eviction, snoop-set sharing and invalidation, and corrupted parity recovered by a refill.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int OFS_W = 5;

  localparam logic [1:0] CPU_RD   = 2'd0;
  localparam logic [1:0] CPU_WR   = 2'd1;
  localparam logic [1:0] CPU_FILL = 2'd2;

  typedef enum logic [2:0] {
    K_RD,
    K_WR,
    K_FILL,
    K_SRD,
    K_SINV
  } kind_e;
endpackage

// File: rtl/ts_arbiter.sv
module ts_arbiter
  import ts_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_fill_shared,
  input  logic [1:0]        cpu_fill_bad_par,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic              snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              sel_valid,
  output logic              sel_snoop,
  output kind_e             sel_kind,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              sel_shared,
  output logic [1:0]        sel_bad
);
  assign snp_ready  = 1'b1;
  assign cpu_ready  = !snp_valid;
  assign sel_valid  = snp_valid || cpu_valid;
  assign sel_snoop  = snp_valid;
  assign sel_addr   = snp_valid ? snp_addr : cpu_addr;
  assign sel_shared = cpu_fill_shared && !snp_valid;
  assign sel_bad    = snp_valid ? 2'b00 : cpu_fill_bad_par;

  always_comb begin
    if (snp_valid) begin
      sel_kind = snp_op ? K_SINV : K_SRD;
    end else begin
      case (cpu_op)
        CPU_WR:   sel_kind = K_WR;
        CPU_FILL: sel_kind = K_FILL;
        default:  sel_kind = K_RD;
      endcase
    end
  end
endmodule

// File: rtl/ts_array.sv
module ts_array #(
  parameter int LINES = 64,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_v,
  output logic             rd_s,
  output logic             rd_d,
  output logic             rd_cpar,
  output logic             rd_tpar,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_v,
  input  logic             wr_s,
  input  logic             wr_d,
  input  logic             wr_cpar,
  input  logic             wr_tpar
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] v_q, s_q, d_q, cp_q, tp_q;

  assign rd_tag  = tag_q[rd_idx];
  assign rd_v    = v_q[rd_idx];
  assign rd_s    = s_q[rd_idx];
  assign rd_d    = d_q[rd_idx];
  assign rd_cpar = cp_q[rd_idx];
  assign rd_tpar = tp_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      s_q  <= '0;
      d_q  <= '0;
      cp_q <= '0;
      tp_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (we) begin
      tag_q[wr_idx] <= wr_tag;
      v_q[wr_idx]   <= wr_v;
      s_q[wr_idx]   <= wr_s;
      d_q[wr_idx]   <= wr_d;
      cp_q[wr_idx]  <= wr_cpar;
      tp_q[wr_idx]  <= wr_tpar;
    end
  end
endmodule

// File: rtl/ts_lookup.sv
module ts_lookup
  import ts_pkg::*;
#(
  parameter int TAG_W = 21
) (
  input  logic             req_valid,
  input  kind_e            kind,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             fill_shared,
  input  logic [1:0]       fill_bad,
  input  logic [TAG_W-1:0] st_tag,
  input  logic             st_v,
  input  logic             st_s,
  input  logic             st_d,
  input  logic             st_cpar,
  input  logic             st_tpar,
  output logic             hit,
  output logic             par_err,
  output logic             wb_req,
  output logic             we,
  output logic [TAG_W-1:0] nx_tag,
  output logic             nx_v,
  output logic             nx_s,
  output logic             nx_d,
  output logic             nx_cpar,
  output logic             nx_tpar
);
  logic is_fill, is_cpu_look, ctrl_bad, tag_bad;

  assign is_fill     = (kind == K_FILL);
  assign is_cpu_look = (kind == K_RD) || (kind == K_WR);
  assign ctrl_bad    = (st_v ^ st_s ^ st_d) ^ st_cpar;
  assign tag_bad     = (^st_tag) ^ st_tpar;
  assign par_err     = req_valid && !is_fill && (ctrl_bad || tag_bad);
  assign hit         = req_valid && !is_fill && !par_err && st_v && (st_tag == req_tag);
  assign wb_req      = req_valid && is_cpu_look && !hit && !par_err && st_v && st_d;

  always_comb begin
    we     = 1'b0;
    nx_tag = st_tag;
    nx_v   = st_v;
    nx_s   = st_s;
    nx_d   = st_d;
    if (req_valid && is_fill) begin
      we     = 1'b1;
      nx_tag = req_tag;
      nx_v   = 1'b1;
      nx_s   = fill_shared;
      nx_d   = 1'b0;
    end else if (hit) begin
      case (kind)
        K_WR:   begin we = 1'b1; nx_d = 1'b1; end
        K_SRD:  begin we = 1'b1; nx_s = 1'b1; end
        K_SINV: begin we = 1'b1; nx_v = 1'b0; end
        default: we = 1'b0;
      endcase
    end
    nx_cpar = (nx_v ^ nx_s ^ nx_d) ^ (is_fill && fill_bad[0]);
    nx_tpar = (^nx_tag) ^ (is_fill && fill_bad[1]);
  end
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store
  import ts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 64,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_fill_shared,
  input  logic [1:0]        cpu_fill_bad_par,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic              snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              rsp_valid,
  output logic              rsp_snoop,
  output logic              rsp_hit,
  output logic              rsp_shared,
  output logic              rsp_dirty,
  output logic              rsp_par_err,
  output logic              rsp_wb_req,
  output logic [TAG_W-1:0]  rsp_wb_tag,
  output logic [IDX_W-1:0]  rsp_wb_idx
);
  logic              sel_valid, sel_snoop, sel_shared;
  kind_e             sel_kind;
  logic [ADDR_W-1:0] sel_addr;
  logic [1:0]        sel_bad;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  req_tag;

  logic [TAG_W-1:0]  st_tag, nx_tag;
  logic st_v, st_s, st_d, st_cpar, st_tpar;
  logic nx_v, nx_s, nx_d, nx_cpar, nx_tpar;
  logic hit, par_err, wb_req, we;

  ts_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_op(cpu_op),
    .cpu_addr(cpu_addr), .cpu_fill_shared(cpu_fill_shared),
    .cpu_fill_bad_par(cpu_fill_bad_par), .snp_valid(snp_valid),
    .snp_ready(snp_ready), .snp_op(snp_op), .snp_addr(snp_addr),
    .sel_valid(sel_valid), .sel_snoop(sel_snoop), .sel_kind(sel_kind),
    .sel_addr(sel_addr), .sel_shared(sel_shared), .sel_bad(sel_bad)
  );

  assign idx     = sel_addr[OFS_W +: IDX_W];
  assign req_tag = sel_addr[ADDR_W-1 -: TAG_W];

  ts_array #(.LINES(LINES), .TAG_W(TAG_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx),
    .rd_tag(st_tag), .rd_v(st_v), .rd_s(st_s), .rd_d(st_d),
    .rd_cpar(st_cpar), .rd_tpar(st_tpar),
    .we(we), .wr_idx(idx), .wr_tag(nx_tag), .wr_v(nx_v), .wr_s(nx_s),
    .wr_d(nx_d), .wr_cpar(nx_cpar), .wr_tpar(nx_tpar)
  );

  ts_lookup #(.TAG_W(TAG_W)) u_look (
    .req_valid(sel_valid), .kind(sel_kind), .req_tag(req_tag),
    .fill_shared(sel_shared), .fill_bad(sel_bad),
    .st_tag(st_tag), .st_v(st_v), .st_s(st_s), .st_d(st_d),
    .st_cpar(st_cpar), .st_tpar(st_tpar),
    .hit(hit), .par_err(par_err), .wb_req(wb_req), .we(we),
    .nx_tag(nx_tag), .nx_v(nx_v), .nx_s(nx_s), .nx_d(nx_d),
    .nx_cpar(nx_cpar), .nx_tpar(nx_tpar)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_snoop   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_shared  <= 1'b0;
      rsp_dirty   <= 1'b0;
      rsp_par_err <= 1'b0;
      rsp_wb_req  <= 1'b0;
      rsp_wb_tag  <= '0;
      rsp_wb_idx  <= '0;
    end else begin
      rsp_valid   <= sel_valid;
      rsp_snoop   <= sel_valid && sel_snoop;
      rsp_hit     <= hit;
      rsp_shared  <= hit && st_s;
      rsp_dirty   <= hit && st_d;
      rsp_par_err <= par_err;
      rsp_wb_req  <= wb_req;
      rsp_wb_tag  <= wb_req ? st_tag : '0;
      rsp_wb_idx  <= wb_req ? idx : '0;
    end
  end

  // R11: an accepted request always yields a response in the next cycle
  a_r11_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_valid && cpu_ready) || (snp_valid && snp_ready)) |=> rsp_valid);

  // R11: no acceptance, no response
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_valid && !snp_valid) |=> !rsp_valid);

  // R10: contention resolves toward the snoop
  a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && snp_valid) |=> (rsp_valid && rsp_snoop));

  // R9: a parity error is never a hit nor a write-back
  a_r9_err_is_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_par_err |-> (!rsp_hit && !rsp_wb_req));

  // R5: write-back only comes from a processor miss
  a_r5_wb_cpu_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wb_req |-> (rsp_valid && !rsp_hit && !rsp_snoop));
endmodule

// File: tb/sim_cache_tag_store.sv
`timescale 1ns/1ps
module sim_cache_tag_store;
  localparam int ADDR_W = 32;
  localparam int LINES  = 64;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_fill_shared = 1'b0, snp_valid = 1'b0, snp_op = 1'b0;
  logic [1:0] cpu_op = 2'd0, cpu_fill_bad_par = 2'd0;
  logic [ADDR_W-1:0] cpu_addr = '0, snp_addr = '0;
  logic cpu_ready, snp_ready, rsp_valid, rsp_snoop, rsp_hit, rsp_shared;
  logic rsp_dirty, rsp_par_err, rsp_wb_req;
  logic [TAG_W-1:0] rsp_wb_tag;
  logic [IDX_W-1:0] rsp_wb_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cache_tag_store #(.ADDR_W(ADDR_W), .LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_fill_shared(cpu_fill_shared),
    .cpu_fill_bad_par(cpu_fill_bad_par), .snp_valid(snp_valid),
    .snp_ready(snp_ready), .snp_op(snp_op), .snp_addr(snp_addr),
    .rsp_valid(rsp_valid), .rsp_snoop(rsp_snoop), .rsp_hit(rsp_hit),
    .rsp_shared(rsp_shared), .rsp_dirty(rsp_dirty), .rsp_par_err(rsp_par_err),
    .rsp_wb_req(rsp_wb_req), .rsp_wb_tag(rsp_wb_tag), .rsp_wb_idx(rsp_wb_idx)
  );

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int ofs);
    return {tag[TAG_W-1:0], idx[IDX_W-1:0], ofs[4:0]};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one processor request; returns at the negedge after the accepting edge
  task automatic cpu_req(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                         input logic sh, input logic [1:0] bad);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = op; cpu_addr = a;
    cpu_fill_shared = sh; cpu_fill_bad_par = bad;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0; cpu_fill_bad_par = 2'b00;
  endtask

  task automatic snp_req(input logic op, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2", "rsp_valid after reset", rsp_valid, 0);
    cpu_req(2'd0, mk(7, 3, 0), 0, 0);
    chk("R11", "rsp_valid", rsp_valid, 1);
    chk("R2", "hit on empty line", rsp_hit, 0);
    chk("R2", "par_err on empty line", rsp_par_err, 0);
    chk("R2", "wb on empty line", rsp_wb_req, 0);
  endtask

  task automatic t_fill_hit;
    cpu_req(2'd2, mk(16'h0abc, 5, 0), 1, 0);
    cpu_req(2'd0, mk(16'h0abc, 5, 7), 0, 0);
    chk("R3", "hit after fill", rsp_hit, 1);
    chk("R3", "shared from fill", rsp_shared, 1);
    chk("R3", "dirty cleared by fill", rsp_dirty, 0);
    cpu_req(2'd0, mk(16'h0abc, 5, 31), 0, 0);
    chk("R1", "other offset same line hits", rsp_hit, 1);
    cpu_req(2'd0, mk(16'h0abd, 5, 7), 0, 0);
    chk("R4", "tag mismatch misses", rsp_hit, 0);
    chk("R6", "clean victim no wb", rsp_wb_req, 0);
  endtask

  task automatic t_write_wb;
    cpu_req(2'd2, mk(16'h1234, 9, 0), 0, 0);
    cpu_req(2'd1, mk(16'h1234, 9, 4), 0, 0);
    chk("R5", "write hit", rsp_hit, 1);
    chk("R5", "dirty before write", rsp_dirty, 0);
    cpu_req(2'd0, mk(16'h1234, 9, 0), 0, 0);
    chk("R5", "dirty after write", rsp_dirty, 1);
    cpu_req(2'd0, mk(16'h4321, 9, 0), 0, 0);
    chk("R5", "wb on dirty victim", rsp_wb_req, 1);
    chk("R5", "victim tag", rsp_wb_tag, 16'h1234);
    chk("R5", "victim index", rsp_wb_idx, 9);
    cpu_req(2'd2, mk(16'h0055, 10, 0), 0, 0);
    cpu_req(2'd1, mk(16'h0066, 10, 0), 0, 0);
    chk("R6", "clean victim write miss no wb", rsp_wb_req, 0);
    chk("R6", "write miss no hit", rsp_hit, 0);
  endtask

  task automatic t_snoop;
    cpu_req(2'd2, mk(16'h0e0e, 12, 0), 0, 0);
    cpu_req(2'd1, mk(16'h0e0e, 12, 0), 0, 0);
    snp_req(1'b0, mk(16'h0e0e, 12, 8));
    chk("R7", "snoop source", rsp_snoop, 1);
    chk("R7", "snoop read hit", rsp_hit, 1);
    chk("R7", "snoop reports dirty", rsp_dirty, 1);
    chk("R7", "shared before snoop", rsp_shared, 0);
    cpu_req(2'd0, mk(16'h0e0e, 12, 0), 0, 0);
    chk("R7", "shared set by snoop", rsp_shared, 1);
    snp_req(1'b1, mk(16'h0e0e, 12, 0));
    chk("R8", "invalidate hit", rsp_hit, 1);
    cpu_req(2'd0, mk(16'h0e0e, 12, 0), 0, 0);
    chk("R8", "miss after invalidate", rsp_hit, 0);
    chk("R8", "no wb after invalidate", rsp_wb_req, 0);
  endtask

  task automatic t_parity;
    cpu_req(2'd2, mk(16'h0777, 20, 0), 0, 2'b01);
    cpu_req(2'd1, mk(16'h0777, 20, 0), 0, 0);
    chk("R9", "flag parity error", rsp_par_err, 1);
    chk("R9", "error forces miss", rsp_hit, 0);
    cpu_req(2'd2, mk(16'h0888, 21, 0), 0, 2'b10);
    cpu_req(2'd0, mk(16'h0999, 21, 0), 0, 0);
    chk("R9", "tag parity error", rsp_par_err, 1);
    chk("R9", "no wb on error", rsp_wb_req, 0);
    cpu_req(2'd2, mk(16'h0888, 21, 0), 0, 0);
    cpu_req(2'd0, mk(16'h0888, 21, 0), 0, 0);
    chk("R12", "refill clears error", rsp_par_err, 0);
    chk("R12", "refill hits", rsp_hit, 1);
    cpu_req(2'd0, mk(16'h0777, 20, 0), 0, 0);
    chk("R9", "errored write left no change", rsp_par_err, 1);
  endtask

  task automatic t_priority;
    cpu_req(2'd2, mk(16'h0321, 30, 0), 0, 0);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd1; cpu_addr = mk(16'h0321, 30, 0);
    snp_valid = 1'b1; snp_op = 1'b0; snp_addr = mk(16'h0321, 30, 0);
    #1;
    chk("R10", "cpu_ready low under snoop", cpu_ready, 0);
    chk("R10", "snp_ready high", snp_ready, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "snoop served first", rsp_snoop, 1);
    chk("R10", "snoop saw clean line", rsp_dirty, 0);
    snp_valid = 1'b0;
    #1;
    chk("R10", "cpu_ready back high", cpu_ready, 1);
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    chk("R10", "held cpu request served", rsp_valid && !rsp_snoop, 1);
    chk("R10", "held write hits", rsp_hit, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "idle cycle no response", rsp_valid, 0);
    cpu_req(2'd0, mk(16'h0321, 30, 0), 0, 0);
    chk("R10", "held write marked dirty", rsp_dirty, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_hit();
    t_write_wb();
    t_snoop();
    t_parity();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule